// File: doc/BRIEF.md
# Receive Slot Lock Arbiter

This block owns a single receive message slot. The host locks it by reading its control word. Next to the slot sits a one-entry holding register. A matched frame that arrives while the slot is locked, or while a copy into it is in progress, goes to the holding register, and the visible slot contents stay unchanged. When the host unlocks the slot, a held frame is moved into the slot over a fixed number of cycles. During those cycles a busy bit in the slot's code field is raised.

The host can deactivate the slot at any time. Deactivation beats locking: it drops the lock, cancels a copy in progress, throws away the held frame and marks the slot inactive. An inactive slot ignores frames until the next matching round starts. A held frame that a newer frame replaces is lost without any indication. The block only routes frames that an upstream matcher has already accepted for this slot.

Top module: `rx_slot_lock_arbiter`

## Requirements
- R1: A frame written while the slot is locked leaves the slot data and code unchanged and is kept in the holding register.
- R2: On an unlock with a held frame, that frame, or a frame arriving in the unlock cycle, is copied in. When the copy ends, the slot shows its data with code FULL (4'b0010).
- R3: A newer frame that arrives while a frame is already held replaces it, and only the newest is copied. No error or lost-message code is shown.
- R4: The busy bit (code bit 0) is high for exactly COPY_CYC (default 4) cycles, starting in the cycle after the unlock edge.
- R5: A control-word read while busy is set, or while the code is EMPTY (4'b0100), does not lock the slot.
- R6: Deactivation takes priority over a read in the same cycle. It clears the lock and sets the code to INACTIVE (4'b0000). Frames are dropped while inactive, and a round-start strobe returns the slot to EMPTY.
- R7: Deactivation discards the held frame and cancels a copy in progress. The discarded frame never reaches the slot, even after a later unlock.
- R8: A frame written to an active, unlocked, idle slot appears on the data output after one clock edge, with code FULL.
- R9: A read of a FULL, non-busy slot sets the lock output after one clock edge.
- R10: An unlock strobe while the slot is not locked has no effect on code, data or lock.
- R11: After reset the code is EMPTY, the lock is low and the data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid_i | input | 1 | Matched frame for this slot is present |
| frm_data_i | input | DW | Frame payload |
| host_rd_i | input | 1 | Host reads the control word (lock request) |
| host_unlock_i | input | 1 | Single-cycle unlock strobe |
| host_deact_i | input | 1 | Deactivate the slot |
| round_start_i | input | 1 | A new matching round begins |
| code_o | output | 4 | Code field: state in bits 3:1, busy in bit 0 |
| locked_o | output | 1 | Slot is locked by the host |
| slot_data_o | output | DW | Frame currently in the slot |

## Verification
The hardest states to reach are the ones where two events meet: a frame that arrives in the same cycle as the unlock that starts a copy, and a deactivation that lands part-way through the copy window. The stimulus table builds up a lock first. It then fills the holding register twice, so that an overwrite happens. After that it times the unlock and deactivate strobes to exact cycle offsets inside the busy window. The bench then keeps idling past where the copy would have ended, which proves that a cancelled transfer never lands in the slot.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;

  // Slot state occupies bits 3:1 of the code field; bit 0 is the busy flag.
  typedef enum logic [2:0] {
    ST_INACTIVE = 3'b000,
    ST_FULL     = 3'b001,
    ST_EMPTY    = 3'b010
  } slot_st_e;

  function automatic logic [3:0] pack_code(slot_st_e st, logic busy);
    return {st, busy};
  endfunction

  // A control-word read locks only a settled, filled slot.
  function automatic logic lock_allowed(slot_st_e st, logic busy);
    return (st == ST_FULL) && !busy;
  endfunction

endpackage

// File: rtl/rxslot_copy_timer.sv
module rxslot_copy_timer #(
  parameter int COPY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(COPY_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (abort)         cnt_q <= '0;
    else if (start)         cnt_q <= CW'(COPY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) && !abort;
endmodule

// File: rtl/rxslot_hold.sv
module rxslot_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          drop,
  input  logic          take,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (drop || take) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ld_data;
    end
  end
endmodule

// File: rtl/rxslot_slot.sv
module rxslot_slot
  import rxslot_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deact,
  input  logic          round_start,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          lock_set,
  input  logic          lock_clr,
  output slot_st_e      st,
  output logic [DW-1:0] data,
  output logic          locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_EMPTY;
      data   <= '0;
      locked <= 1'b0;
    end else if (deact) begin
      st     <= ST_INACTIVE;
      locked <= 1'b0;
    end else begin
      if (wr_en) begin
        st   <= ST_FULL;
        data <= wr_data;
      end else if (round_start && st == ST_INACTIVE) begin
        st <= ST_EMPTY;
      end
      if (lock_set)      locked <= 1'b1;
      else if (lock_clr) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_slot_lock_arbiter.sv
module rx_slot_lock_arbiter
  import rxslot_pkg::*;
#(
  parameter int DW       = 8,
  parameter int COPY_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid_i,
  input  logic [DW-1:0] frm_data_i,
  input  logic          host_rd_i,
  input  logic          host_unlock_i,
  input  logic          host_deact_i,
  input  logic          round_start_i,
  output logic [3:0]    code_o,
  output logic          locked_o,
  output logic [DW-1:0] slot_data_o
);
  slot_st_e      st;
  logic          locked;
  logic          busy;
  logic          copy_done;
  logic          hold_valid;
  logic [DW-1:0] hold_data;

  // Named internal events
  logic          active;
  logic          frm_to_hold;
  logic          frm_to_slot;
  logic          hold_next_valid;
  logic [DW-1:0] hold_next_data;
  logic          unlock_ok;
  logic          copy_start;
  logic          lock_grant;
  logic          slot_wr;
  logic [DW-1:0] slot_wr_data;

  assign active          = (st != ST_INACTIVE);
  assign frm_to_hold     = frm_valid_i && active && (locked || busy) && !host_deact_i;
  assign frm_to_slot     = frm_valid_i && active && !locked && !busy && !host_deact_i;
  assign hold_next_valid = hold_valid || frm_to_hold;
  assign hold_next_data  = frm_to_hold ? frm_data_i : hold_data;
  assign unlock_ok       = host_unlock_i && locked && !host_deact_i;
  assign copy_start      = unlock_ok && hold_next_valid;
  assign lock_grant      = host_rd_i && lock_allowed(st, busy) && !host_deact_i;
  assign slot_wr         = frm_to_slot || copy_done;
  assign slot_wr_data    = copy_done ? hold_next_data : frm_data_i;

  rxslot_copy_timer #(.COPY_CYC(COPY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (copy_start),
    .abort (host_deact_i),
    .busy  (busy),
    .done  (copy_done)
  );

  rxslot_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frm_to_hold),
    .ld_data (frm_data_i),
    .drop    (host_deact_i),
    .take    (copy_done),
    .valid   (hold_valid),
    .data    (hold_data)
  );

  rxslot_slot #(.DW(DW)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .deact       (host_deact_i),
    .round_start (round_start_i),
    .wr_en       (slot_wr),
    .wr_data     (slot_wr_data),
    .lock_set    (lock_grant),
    .lock_clr    (unlock_ok),
    .st          (st),
    .data        (slot_data_o),
    .locked      (locked)
  );

  assign code_o   = pack_code(st, busy);
  assign locked_o = locked;
endmodule

// File: rtl/rxslot_checker.sv
module rxslot_checker #(
  parameter int DW       = 8,
  parameter int COPY_CYC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_valid_i,
  input logic          host_rd_i,
  input logic          host_deact_i,
  input logic [3:0]    code_o,
  input logic          locked_o,
  input logic [DW-1:0] slot_data_o,
  input logic          hold_valid,
  input logic          copy_done
);
  localparam int BW = $clog2(COPY_CYC + 1) + 1;

  logic [BW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_run <= '0;
    else if (code_o[0]) busy_run <= busy_run + BW'(1);
    else                busy_run <= '0;
  end

  // R1: a frame for a locked slot lands in the holding register
  p_locked_frame_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && locked_o && !host_deact_i) |=> (hold_valid && slot_data_o == $past(slot_data_o)));

  // R2: a finished copy leaves the slot FULL
  p_copy_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> (code_o == 4'b0010));

  // R4: busy never lasts longer than the copy window
  p_busy_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_o[0] |-> (busy_run < BW'(COPY_CYC)));

  // R4: an uninterrupted copy lasts the full window
  p_busy_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(code_o[0]) && !$past(host_deact_i)) |-> (busy_run == BW'(COPY_CYC)));

  // R5: a lock only follows a read of a settled FULL slot
  p_lock_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> ($past(code_o) == 4'b0010 && $past(host_rd_i)));

  // R6: deactivation clears lock and marks the slot inactive
  p_deact_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_deact_i |=> (!locked_o && code_o == 4'b0000));

  // R7: deactivation empties the holding register
  p_deact_drops_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_deact_i |=> !hold_valid);

  // R9: a read of a FULL, idle, unlocked slot locks it
  p_read_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && code_o == 4'b0010 && !host_deact_i) |=> locked_o);
endmodule

bind rx_slot_lock_arbiter rxslot_checker #(.DW(DW), .COPY_CYC(COPY_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frm_valid_i  (frm_valid_i),
  .host_rd_i    (host_rd_i),
  .host_deact_i (host_deact_i),
  .code_o       (code_o),
  .locked_o     (locked_o),
  .slot_data_o  (slot_data_o),
  .hold_valid   (hold_valid),
  .copy_done    (copy_done)
);

// File: tb/test_rx_slot_lock_arbiter.sv
`timescale 1ns/100ps
module test_rx_slot_lock_arbiter;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frm_valid_i = 1'b0;
  logic [DW-1:0] frm_data_i = '0;
  logic          host_rd_i = 1'b0;
  logic          host_unlock_i = 1'b0;
  logic          host_deact_i = 1'b0;
  logic          round_start_i = 1'b0;
  logic [3:0]    code_o;
  logic          locked_o;
  logic [DW-1:0] slot_data_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_slot_lock_arbiter #(.DW(DW), .COPY_CYC(4)) i_rx_slot_lock_arbiter (
    .clk, .rst_n, .frm_valid_i, .frm_data_i, .host_rd_i, .host_unlock_i,
    .host_deact_i, .round_start_i, .code_o, .locked_o, .slot_data_o
  );

  typedef struct packed {
    logic       fv;
    logic [7:0] fd;
    logic       rd;
    logic       ul;
    logic       dv;
    logic       rs;
    logic [3:0] ec;
    logic       el;
    logic [7:0] ed;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 39;
  // Codes: INACTIVE 0, FULL 2, FULL+busy 3, EMPTY 4
  localparam vec_t VEC [NV] = '{
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,4'h4,1'b0,8'h00,4'd5},  // R5 read on EMPTY
    '{1'b1,8'hA5,1'b0,1'b0,1'b0,1'b0,4'h2,1'b0,8'hA5,4'd8},  // R8 direct write
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h2,1'b0,8'hA5,4'd8},
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,4'h2,1'b1,8'hA5,4'd9},  // R9 lock
    '{1'b1,8'h3C,1'b0,1'b0,1'b0,1'b0,4'h2,1'b1,8'hA5,4'd1},  // R1 held
    '{1'b1,8'h7E,1'b0,1'b0,1'b0,1'b0,4'h2,1'b1,8'hA5,4'd3},  // R3 overwrite
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,4'h3,1'b0,8'hA5,4'd4},  // R4 busy 1
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,4'h3,1'b0,8'hA5,4'd5},  // R5 read while busy
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h3,1'b0,8'hA5,4'd4},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h3,1'b0,8'hA5,4'd4},  // R4 busy 4
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h2,1'b0,8'h7E,4'd3},  // R3 newest copied
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,4'h2,1'b0,8'h7E,4'd10}, // R10 stray unlock
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h2,1'b0,8'h7E,4'd10},
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,4'h2,1'b1,8'h7E,4'd9},
    '{1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,4'h2,1'b1,8'h7E,4'd1},
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,8'h7E,4'd6},  // R6 deact locked
    '{1'b1,8'h22,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,8'h7E,4'd6},  // R6 frame dropped
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,4'h4,1'b0,8'h7E,4'd6},  // R6 round start
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,4'h4,1'b0,8'h7E,4'd7},  // R7 no late copy
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h4,1'b0,8'h7E,4'd7},
    '{1'b1,8'h44,1'b0,1'b0,1'b0,1'b0,4'h2,1'b0,8'h44,4'd8},
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,4'h2,1'b1,8'h44,4'd9},
    '{1'b1,8'h55,1'b0,1'b0,1'b0,1'b0,4'h2,1'b1,8'h44,4'd1},
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,4'h3,1'b0,8'h44,4'd4},
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,8'h44,4'd7},  // R7 abort copy
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,8'h44,4'd7},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,8'h44,4'd7},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,8'h44,4'd7},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,4'h4,1'b0,8'h44,4'd6},
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,4'h4,1'b0,8'h44,4'd5},
    '{1'b1,8'h66,1'b0,1'b0,1'b0,1'b0,4'h2,1'b0,8'h66,4'd8},
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,4'h2,1'b1,8'h66,4'd9},
    '{1'b1,8'h77,1'b0,1'b1,1'b0,1'b0,4'h3,1'b0,8'h66,4'd2},  // R2 frame in unlock cycle
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h3,1'b0,8'h66,4'd4},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h3,1'b0,8'h66,4'd4},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h3,1'b0,8'h66,4'd4},
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,4'h2,1'b0,8'h77,4'd2},  // R2 copy landed
    '{1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,8'h77,4'd6},  // R6 deact beats read
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,4'h4,1'b0,8'h77,4'd6}
  };

  task automatic check_out(input int req, input int step,
                           input logic [3:0] ec, input logic el, input logic [7:0] ed);
    checks++;
    if (code_o !== ec || locked_o !== el || slot_data_o !== ed) begin
      failures++;
      $display("FAIL R%0d step %0d: actual code=%h lock=%b data=%h expected code=%h lock=%b data=%h",
               req, step, code_o, locked_o, slot_data_o, ec, el, ed);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_out(11, -1, 4'h4, 1'b0, 8'h00);   // R11 reset state
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      frm_valid_i   = VEC[i].fv;
      frm_data_i    = VEC[i].fd;
      host_rd_i     = VEC[i].rd;
      host_unlock_i = VEC[i].ul;
      host_deact_i  = VEC[i].dv;
      round_start_i = VEC[i].rs;
      @(posedge clk);
      #1;
      check_out(int'(VEC[i].rq), i, VEC[i].ec, VEC[i].el, VEC[i].ed);
    end

    // Directed: lock a freshly written slot, then reset mid-run (R11)
    @(negedge clk);
    frm_valid_i = 1'b1; frm_data_i = 8'h9A;
    host_rd_i = 1'b0; host_unlock_i = 1'b0; host_deact_i = 1'b0; round_start_i = 1'b0;
    @(negedge clk);
    frm_valid_i = 1'b0; host_rd_i = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
    #1;
    check_out(9, 100, 4'h2, 1'b1, 8'h9A);   // R9 lock after write
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check_out(11, 101, 4'h4, 1'b0, 8'h00);  // R11 reset while locked
    @(negedge clk);
    rst_n = 1'b1;
    // Directed: unlock on an EMPTY slot after reset has no effect (R10)
    host_unlock_i = 1'b1;
    @(negedge clk);
    host_unlock_i = 1'b0;
    repeat (2) @(negedge clk);
    check_out(10, 102, 4'h4, 1'b0, 8'h00);
    finish_run();
  end
endmodule